// File: doc/BRIEF.md
# String Transfer Address Sequencer

This block walks a source string and a destination string through memory, one element per handshake. It holds a source index, a destination index, an element counter, two segment bases and a direction flag. While a transfer is pending it presents a 20-bit source address, formed from the source segment and source index, and a 20-bit destination address, formed from the destination segment and destination index. Each address is the segment shifted left by four bits plus the index.

A companion memory agent acknowledges each element. On each acknowledge both indices move by the element size, one for bytes and two for words. They move upward when the direction flag is clear and downward when it is set. Without the repeat option one element is moved. With it, the counter counts the elements down and the run stops when the counter reaches zero. A run started with a zero count moves nothing.

The controller has three states. IDLE accepts register loads, direction commands and `start`. MOVE holds `xfer_req` high until `xfer_ack`. DONE raises `done` for one cycle and then returns to IDLE. The transitions are:

- start-single or start-repeat with a nonzero count: IDLE to MOVE.
- start-repeat with a zero count: IDLE to DONE.
- ack-continue, taken when repeat is on and the count before the ack is above one: MOVE stays in MOVE.
- ack-last, taken for a single transfer or for the final counted element: MOVE to DONE.
- wrap-up: DONE to IDLE.

Top module: `string_seq_top`

## Requirements
- R1: While `xfer_req` is high, `src_addr` = ({src segment, 4'b0} + src index) mod 2^20 and `dst_addr` = ({dst segment, 4'b0} + dst index) mod 2^20.
- R2: On each acknowledged element, both indices change by 1 (`wide`=0) or 2 (`wide`=1). They rise when `dir_flag`=0 and fall when `dir_flag`=1. They wrap modulo 2^16, and the segment registers are left unchanged.
- R3: `dir_set` makes `dir_flag` 1 and `dir_clr` makes it 0. When both are high, set wins.
- R4: While `busy` is high, `dir_set`, `dir_clr`, `ld_en` and `start` have no effect.
- R5: A start with `rep_en`=0 moves exactly one element. `done` rises in the cycle after its ack, and the count is left unchanged.
- R6: A start with `rep_en`=1 and count N>0 issues N requests. The count falls by one per ack, and `done` rises in the cycle after the ack that brings it to zero.
- R7: A start with `rep_en`=1 and count 0 raises `done` in the next cycle, never raises `xfer_req`, and leaves the indices unchanged.
- R8: Without `xfer_ack`, `xfer_req` stays high, and both addresses and both indices stay stable.
- R9: After reset the block is idle. `xfer_req`, `done` and `busy` are low, and the indices, the count and `dir_flag` are zero.
- R10: `done` is high for exactly one cycle per run, and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load segments, indices and count (idle only) |
| ld_src_seg | input | 16 | Source segment value to load |
| ld_src_idx | input | 16 | Source index value to load |
| ld_dst_seg | input | 16 | Destination segment value to load |
| ld_dst_idx | input | 16 | Destination index value to load |
| ld_count | input | 16 | Element count value to load |
| dir_set | input | 1 | Command: make direction downward |
| dir_clr | input | 1 | Command: make direction upward |
| start | input | 1 | Begin a run (idle only) |
| rep_en | input | 1 | Run is counted-repeat |
| wide | input | 1 | Element is a word (1) or a byte (0) |
| xfer_ack | input | 1 | Memory agent finished current element |
| xfer_req | output | 1 | Element transfer pending |
| src_addr | output | 20 | Source physical address |
| dst_addr | output | 20 | Destination physical address |
| src_idx | output | 16 | Current source index |
| dst_idx | output | 16 | Current destination index |
| count | output | 16 | Current element count |
| dir_flag | output | 1 | Direction flag (1 = downward) |
| busy | output | 1 | Run in progress (MOVE or DONE) |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with its default widths: 16-bit segments, indices and count, with a four-bit segment shift. At these widths, vectors with a segment of FFFF or an index near FFFF reach both wrap points, the 20-bit address carry and the 16-bit index carry, in one or two elements. The same 16-bit count width means a counted run of three elements exercises the ack-continue and ack-last transitions without long runs.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    localparam int NUM_CH = 2;   // channel 0 = source, channel 1 = destination

endpackage

// File: rtl/strseq_agen.sv
module strseq_agen #(
    parameter int SEG_W = 16,
    parameter int IDX_W = 16,
    parameter int SHIFT = 4
) (
    input  logic [SEG_W-1:0]       seg,
    input  logic [IDX_W-1:0]       idx,
    output logic [SEG_W+SHIFT-1:0] phys
);
    localparam int ADDR_W = SEG_W + SHIFT;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offs;

    assign base = {seg, {SHIFT{1'b0}}};
    assign offs = ADDR_W'(idx);
    assign phys = base + offs;   // carry out of the top bit is dropped

endmodule

// File: rtl/strseq_stepper.sv
module strseq_stepper #(
    parameter int IDX_W = 16
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             dec,
    input  logic             wide,
    output logic [IDX_W-1:0] nxt
);
    logic [IDX_W-1:0] stride;

    assign stride = wide ? IDX_W'(2) : IDX_W'(1);
    assign nxt    = dec ? (idx - stride) : (idx + stride);

endmodule

// File: rtl/string_seq_top.sv
module string_seq_top #(
    parameter int SEG_W = 16,
    parameter int IDX_W = 16,
    parameter int CNT_W = 16,
    parameter int SHIFT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_en,
    input  logic [SEG_W-1:0]       ld_src_seg,
    input  logic [IDX_W-1:0]       ld_src_idx,
    input  logic [SEG_W-1:0]       ld_dst_seg,
    input  logic [IDX_W-1:0]       ld_dst_idx,
    input  logic [CNT_W-1:0]       ld_count,
    input  logic                   dir_set,
    input  logic                   dir_clr,
    input  logic                   start,
    input  logic                   rep_en,
    input  logic                   wide,
    input  logic                   xfer_ack,
    output logic                   xfer_req,
    output logic [SEG_W+SHIFT-1:0] src_addr,
    output logic [SEG_W+SHIFT-1:0] dst_addr,
    output logic [IDX_W-1:0]       src_idx,
    output logic [IDX_W-1:0]       dst_idx,
    output logic [CNT_W-1:0]       count,
    output logic                   dir_flag,
    output logic                   busy,
    output logic                   done
);
    import strseq_pkg::*;

    localparam int ADDR_W = SEG_W + SHIFT;

    seq_state_e       state_q, state_d;
    logic [SEG_W-1:0] seg_q  [NUM_CH];
    logic [IDX_W-1:0] idx_q  [NUM_CH];
    logic [IDX_W-1:0] idx_nx [NUM_CH];
    logic [ADDR_W-1:0] phys  [NUM_CH];
    logic [IDX_W-1:0] ld_idx [NUM_CH];
    logic [SEG_W-1:0] ld_seg [NUM_CH];
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             rep_q;
    logic             wide_q;
    logic             ack_now;
    logic             last_elem;

    assign ld_idx[0] = ld_src_idx;
    assign ld_idx[1] = ld_dst_idx;
    assign ld_seg[0] = ld_src_seg;
    assign ld_seg[1] = ld_dst_seg;

    // Address former and index stepper per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        strseq_agen #(
            .SEG_W (SEG_W),
            .IDX_W (IDX_W),
            .SHIFT (SHIFT)
        ) u_agen (
            .seg  (seg_q[ch]),
            .idx  (idx_q[ch]),
            .phys (phys[ch])
        );

        strseq_stepper #(
            .IDX_W (IDX_W)
        ) u_step (
            .idx  (idx_q[ch]),
            .dec  (dir_q),
            .wide (wide_q),
            .nxt  (idx_nx[ch])
        );
    end

    assign ack_now   = (state_q == ST_MOVE) && xfer_ack;
    assign last_elem = !rep_q || (cnt_q == CNT_W'(1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (rep_en && (cnt_q == '0)) ? ST_DONE : ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (xfer_ack) begin
                    state_d = last_elem ? ST_DONE : ST_MOVE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        xfer_req = 1'b0;
        done     = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE: busy     = 1'b0;
            ST_MOVE: xfer_req = 1'b1;
            ST_DONE: done     = 1'b1;
            default: busy     = 1'b0;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                seg_q[ch] <= '0;
                idx_q[ch] <= '0;
            end
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            rep_q  <= 1'b0;
            wide_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (ld_en) begin
                for (int ch = 0; ch < NUM_CH; ch++) begin
                    seg_q[ch] <= ld_seg[ch];
                    idx_q[ch] <= ld_idx[ch];
                end
                cnt_q <= ld_count;
            end
            if (dir_set) begin
                dir_q <= 1'b1;
            end else if (dir_clr) begin
                dir_q <= 1'b0;
            end
            if (start) begin
                rep_q  <= rep_en;
                wide_q <= wide;
            end
        end else if (ack_now) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                idx_q[ch] <= idx_nx[ch];
            end
            if (rep_q) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign src_addr = phys[0];
    assign dst_addr = phys[1];
    assign src_idx  = idx_q[0];
    assign dst_idx  = idx_q[1];
    assign count    = cnt_q;
    assign dir_flag = dir_q;

endmodule

// File: rtl/strseq_checker.sv
module strseq_checker #(
    parameter int IDX_W  = 16,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_req,
    input logic              xfer_ack,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [IDX_W-1:0]  src_idx,
    input logic [IDX_W-1:0]  dst_idx,
    input logic [CNT_W-1:0]  count,
    input logic              dir_flag,
    input logic              busy,
    input logic              done,
    input logic              start,
    input logic              rep_en,
    input logic              rep_q,
    input logic              wide_q
);
    logic [IDX_W-1:0] stride_c;
    logic [IDX_W-1:0] exp_src_nx;
    logic [IDX_W-1:0] exp_dst_nx;

    assign stride_c   = wide_q ? IDX_W'(2) : IDX_W'(1);
    assign exp_src_nx = dir_flag ? (src_idx - stride_c) : (src_idx + stride_c);
    assign exp_dst_nx = dir_flag ? (dst_idx - stride_c) : (dst_idx + stride_c);

    assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack) |=> (src_idx == $past(exp_src_nx)) && (dst_idx == $past(exp_dst_nx)));

    assert_dir_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dir_flag));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && rep_q) |=> (count == $past(count) - CNT_W'(1)));

    assert_single_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && !rep_q) |=> $stable(count) && done);

    assert_zero_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && rep_en && (count == '0)) |=> (done && !xfer_req));

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(src_addr) && $stable(dst_addr)
                                     && $stable(src_idx) && $stable(dst_idx)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

bind string_seq_top strseq_checker #(
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W),
    .ADDR_W (SEG_W + SHIFT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer_req (xfer_req),
    .xfer_ack (xfer_ack),
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .src_idx  (src_idx),
    .dst_idx  (dst_idx),
    .count    (count),
    .dir_flag (dir_flag),
    .busy     (busy),
    .done     (done),
    .start    (start),
    .rep_en   (rep_en),
    .rep_q    (rep_q),
    .wide_q   (wide_q)
);

// File: tb/tb_string_seq_top.sv
module tb_string_seq_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_src_seg = '0, ld_src_idx = '0, ld_dst_seg = '0, ld_dst_idx = '0, ld_count = '0;
    logic        dir_set = 1'b0, dir_clr = 1'b0, start = 1'b0, rep_en = 1'b0, wide = 1'b0, xfer_ack = 1'b0;
    logic        xfer_req, dir_flag, busy, done;
    logic [19:0] src_addr, dst_addr;
    logic [15:0] src_idx, dst_idx, count;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct packed {
        logic [15:0] ds;
        logic [15:0] si;
        logic [15:0] es;
        logic [15:0] di;
        logic        dec;
        logic        wd;
        logic [19:0] src;
        logic [19:0] dst;
        logic [15:0] si_n;
        logic [15:0] di_n;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{16'h4569, 16'h10A0, 16'h2000, 16'h0010, 1'b0, 1'b0, 20'h46730, 20'h20010, 16'h10A1, 16'h0011},
        '{16'h1000, 16'h0004, 16'h3000, 16'h0100, 1'b1, 1'b1, 20'h10004, 20'h30100, 16'h0002, 16'h00FE},
        '{16'hF000, 16'hFFFF, 16'h0001, 16'hFFFE, 1'b0, 1'b1, 20'hFFFFF, 20'h1000E, 16'h0001, 16'h0000},
        '{16'hFFFF, 16'h0010, 16'h1234, 16'h0000, 1'b1, 1'b0, 20'h00000, 20'h12340, 16'h000F, 16'hFFFF}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    string_seq_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_en),
        .ld_src_seg (ld_src_seg),
        .ld_src_idx (ld_src_idx),
        .ld_dst_seg (ld_dst_seg),
        .ld_dst_idx (ld_dst_idx),
        .ld_count   (ld_count),
        .dir_set    (dir_set),
        .dir_clr    (dir_clr),
        .start      (start),
        .rep_en     (rep_en),
        .wide       (wide),
        .xfer_ack   (xfer_ack),
        .xfer_req   (xfer_req),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .src_idx    (src_idx),
        .dst_idx    (dst_idx),
        .count      (count),
        .dir_flag   (dir_flag),
        .busy       (busy),
        .done       (done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_regs(input logic [15:0] ds, input logic [15:0] si, input logic [15:0] es,
                             input logic [15:0] di, input logic [15:0] cnt);
        ld_en = 1'b1; ld_src_seg = ds; ld_src_idx = si; ld_dst_seg = es; ld_dst_idx = di; ld_count = cnt;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic dir_cmd(input logic s, input logic c);
        dir_set = s; dir_clr = c;
        @(negedge clk);
        dir_set = 1'b0; dir_clr = 1'b0;
    endtask

    task automatic start_run(input logic rep, input logic wd);
        start = 1'b1; rep_en = rep; wide = wd;
        @(negedge clk);
        start = 1'b0; rep_en = 1'b0; wide = 1'b0;
    endtask

    task automatic ack_one();
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 req", 32'(xfer_req), 32'd0);
        chk("R9 busy", 32'(busy), 32'd0);
        chk("R9 done", 32'(done), 32'd0);
        chk("R9 dir", 32'(dir_flag), 32'd0);
        chk("R9 regs", {src_idx, count}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: single transfers (R1, R2, R5)
        for (int v = 0; v < 4; v++) begin
            load_regs(VECS[v].ds, VECS[v].si, VECS[v].es, VECS[v].di, 16'd5);
            dir_cmd(VECS[v].dec, !VECS[v].dec);
            start_run(1'b0, VECS[v].wd);
            chk("R1 req", 32'(xfer_req), 32'd1);
            chk("R1 src_addr", 32'(src_addr), 32'(VECS[v].src));
            chk("R1 dst_addr", 32'(dst_addr), 32'(VECS[v].dst));
            ack_one();
            chk("R5 done", 32'(done), 32'd1);
            chk("R5 req low", 32'(xfer_req), 32'd0);
            chk("R2 src_idx", 32'(src_idx), 32'(VECS[v].si_n));
            chk("R2 dst_idx", 32'(dst_idx), 32'(VECS[v].di_n));
            chk("R5 count kept", 32'(count), 32'd5);
            @(negedge clk);
            chk("R10 done once", 32'(done), 32'd0);
            chk("R10 idle", 32'(busy), 32'd0);
        end

        // R6 / R8: counted word run of three, upward
        load_regs(16'h0100, 16'h0000, 16'h0200, 16'h0040, 16'd3);
        dir_cmd(1'b0, 1'b1);
        start_run(1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            chk("R6 req", 32'(xfer_req), 32'd1);
            chk("R6 src_addr", 32'(src_addr), 32'h01000 + 32'(2 * k));
            chk("R6 dst_addr", 32'(dst_addr), 32'h02040 + 32'(2 * k));
            chk("R6 count", 32'(count), 32'(3 - k));
            if (k == 1) begin
                @(negedge clk);
                chk("R8 req held", 32'(xfer_req), 32'd1);
                chk("R8 src stable", 32'(src_addr), 32'h01002);
                chk("R8 idx stable", 32'(dst_idx), 32'h0042);
            end
            ack_one();
            if (k < 2) chk("R6 no early done", 32'(done), 32'd0);
        end
        chk("R6 done", 32'(done), 32'd1);
        chk("R6 count zero", 32'(count), 32'd0);
        chk("R6 src_idx", 32'(src_idx), 32'h0006);
        @(negedge clk);

        // R7: counted run with zero count
        load_regs(16'h0100, 16'h0055, 16'h0200, 16'h0066, 16'd0);
        start_run(1'b1, 1'b0);
        chk("R7 done", 32'(done), 32'd1);
        chk("R7 no req", 32'(xfer_req), 32'd0);
        @(negedge clk);
        chk("R7 idle", 32'(busy), 32'd0);
        chk("R7 src_idx kept", 32'(src_idx), 32'h0055);
        chk("R7 dst_idx kept", 32'(dst_idx), 32'h0066);

        // R4: commands and loads ignored while busy
        load_regs(16'h0300, 16'h0010, 16'h0400, 16'h0020, 16'd2);
        start_run(1'b1, 1'b0);
        dir_set = 1'b1; ld_en = 1'b1; ld_src_idx = 16'hAAAA; ld_count = 16'd9; start = 1'b1;
        @(negedge clk);
        dir_set = 1'b0; ld_en = 1'b0; start = 1'b0;
        chk("R4 dir kept", 32'(dir_flag), 32'd0);
        chk("R4 src_addr kept", 32'(src_addr), 32'h03010);
        chk("R4 count kept", 32'(count), 32'd2);
        ack_one();
        chk("R4 step upward", 32'(src_idx), 32'h0011);
        ack_one();
        chk("R4 run ends", 32'(done), 32'd1);
        @(negedge clk);

        // R3: direction commands, set wins over clear
        dir_cmd(1'b1, 1'b1);
        chk("R3 both sets", 32'(dir_flag), 32'd1);
        dir_cmd(1'b0, 1'b1);
        chk("R3 clear", 32'(dir_flag), 32'd0);
        dir_cmd(1'b1, 1'b0);
        chk("R3 set", 32'(dir_flag), 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule